// File: doc/BRIEF.md
# Sticky-Error Accumulator Calculator

This block is a clocked accumulator with a data width set by a parameter (16 bits by default). It has four one-bit operation strobes: clear, load, add and complement. The accumulator register drives the result port directly, so an operation sampled at a rising edge shows on the result after that edge. Each operation reads the data input and the current accumulator contents.

An unsigned add that carries out of the top bit counts as a failure. On that cycle the accumulator keeps its old value and a sticky error flag is set. While the flag is set, the block ignores every operation except clear. Clear zeroes both the accumulator and the flag. When several strobes are high in the same cycle, one fixed priority decides which operation runs. A synchronous reset puts the block in the same state that clear does.

Top module: `acc_calc`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the accumulator becomes all zeros and `err_out` becomes 0 after that edge.
- R2: A cycle with `clr_op` high zeroes the accumulator and drops `err_out`. This holds even when the error flag is set and other strobes are high.
- R3: With no error pending and `clr_op` low, `load_op` copies `din` into the accumulator.
- R4: With no error pending and only `add_op` of the operation strobes high, the accumulator becomes accumulator + `din`, provided no carry leaves the top bit. This includes a sum that lands exactly on all ones.
- R5: An add whose unsigned sum carries out of the top bit leaves the accumulator unchanged and sets `err_out` to 1.
- R6: With no error pending and only `inv_op` high, the accumulator becomes its own bitwise inverse.
- R7: While `err_out` is 1 and `clr_op` is low, `load_op`, `add_op` and `inv_op` change neither the accumulator nor the flag.
- R8: When strobes coincide, the priority runs from highest to lowest as clear, load, add, complement. Only the highest-priority operation takes effect.
- R9: A cycle with no strobe high leaves the accumulator and `err_out` unchanged, whatever `din` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr_op | input | 1 | Clear strobe: zero the accumulator and the error flag |
| load_op | input | 1 | Load strobe: accumulator takes `din` |
| add_op | input | 1 | Add strobe: accumulator takes accumulator + `din` |
| inv_op | input | 1 | Complement strobe: accumulator takes its bitwise inverse |
| din | input | W (16) | Operand data |
| acc_out | output | W (16) | Current accumulator contents |
| err_out | output | 1 | Sticky error flag |

## Verification
The bench builds the block with W = 16. The carry boundary is therefore at 16'hFFFF, and directed values can reach both sides of it: FFFE + 1 fills the register to all ones without error, and FFFF + 1 overflows. With this width, the operand patterns also let each lower-priority strobe produce a result that differs from the winner's result. A strobe that was wrongly obeyed therefore changes the observed accumulator value. The error lock is driven with every blocked strobe in turn, and then with clear combined with other strobes.

// File: rtl/acc_calc_pkg.sv
package acc_calc_pkg;

  // Operation selected for one cycle after priority resolution.
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_ADD   = 3'd3,
    OP_INV   = 3'd4
  } acc_op_e;

endpackage

// File: rtl/acc_op_decode.sv
module acc_op_decode
  import acc_calc_pkg::*;
(
  input  logic    clr_op,
  input  logic    load_op,
  input  logic    add_op,
  input  logic    inv_op,
  output acc_op_e op
);

  // Fixed priority: clear beats load, load beats add, add beats complement.
  always_comb begin
    if (clr_op)       op = OP_CLEAR;
    else if (load_op) op = OP_LOAD;
    else if (add_op)  op = OP_ADD;
    else if (inv_op)  op = OP_INV;
    else              op = OP_NONE;
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_calc_pkg::*;
#(
  parameter int W = 16
) (
  input  acc_op_e        op,
  input  logic [W-1:0]   acc,
  input  logic [W-1:0]   din,
  input  logic           err,
  output logic [W-1:0]   nxt_acc,
  output logic           nxt_err,
  output logic           ovf_evt,
  output logic           lock_evt
);

  localparam int SUM_W = W + 1;

  // Unsigned add that keeps the carry in the top bit.
  function automatic logic [SUM_W-1:0] add_carry(input logic [W-1:0] a,
                                                 input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [W-1:0] invert(input logic [W-1:0] a);
    return ~a;
  endfunction

  logic [SUM_W-1:0] sum_full;
  assign sum_full = add_carry(acc, din);

  // Named events for the checker.
  assign ovf_evt  = (op == OP_ADD) && !err && sum_full[W];
  assign lock_evt = err && (op != OP_CLEAR) && (op != OP_NONE);

  always_comb begin
    nxt_acc = acc;
    nxt_err = err;
    if (op == OP_CLEAR) begin
      nxt_acc = '0;
      nxt_err = 1'b0;
    end else if (!err) begin
      unique case (op)
        OP_LOAD: nxt_acc = din;
        OP_ADD: begin
          if (sum_full[W]) nxt_err = 1'b1;
          else             nxt_acc = sum_full[W-1:0];
        end
        OP_INV:  nxt_acc = invert(acc);
        default: nxt_acc = acc;
      endcase
    end
  end

endmodule

// File: rtl/acc_calc.sv
module acc_calc
  import acc_calc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_op,
  input  logic         load_op,
  input  logic         add_op,
  input  logic         inv_op,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc_out,
  output logic         err_out
);

  acc_op_e      op;
  logic [W-1:0] acc_q, nxt_acc;
  logic         err_q, nxt_err;
  logic         ovf_evt, lock_evt;

  acc_op_decode u_dec (
    .clr_op  (clr_op),
    .load_op (load_op),
    .add_op  (add_op),
    .inv_op  (inv_op),
    .op      (op)
  );

  acc_alu #(.W(W)) u_alu (
    .op       (op),
    .acc      (acc_q),
    .din      (din),
    .err      (err_q),
    .nxt_acc  (nxt_acc),
    .nxt_err  (nxt_err),
    .ovf_evt  (ovf_evt),
    .lock_evt (lock_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      err_q <= 1'b0;
    end else begin
      acc_q <= nxt_acc;
      err_q <= nxt_err;
    end
  end

  assign acc_out = acc_q;
  assign err_out = err_q;

endmodule

// File: rtl/acc_calc_chk.sv
module acc_calc_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         clr_op,
  input logic         load_op,
  input logic         add_op,
  input logic         inv_op,
  input logic [W-1:0] din,
  input logic [W-1:0] acc,
  input logic         err,
  input logic         ovf_evt,
  input logic         lock_evt
);

  // R1
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (acc == '0 && !err));

  // R2
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    clr_op |=> (acc == '0 && !err));

  // R3
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!err && !clr_op && load_op) |=> (acc == $past(din)));

  // R5
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> (err && $stable(acc)));

  // R7
  p_lock_r7: assert property (@(posedge clk) disable iff (rst)
    lock_evt |=> (err && $stable(acc)));

  // R9
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!clr_op && !load_op && !add_op && !inv_op) |=> ($stable(acc) && $stable(err)));

endmodule

bind acc_calc acc_calc_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr_op   (clr_op),
  .load_op  (load_op),
  .add_op   (add_op),
  .inv_op   (inv_op),
  .din      (din),
  .acc      (acc_out),
  .err      (err_out),
  .ovf_evt  (ovf_evt),
  .lock_evt (lock_evt)
);

// File: tb/sim_acc_calc.sv
module sim_acc_calc;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clr_op = 1'b0, load_op = 1'b0, add_op = 1'b0, inv_op = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] acc_out;
  logic         err_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acc_calc #(.W(W)) u0 (
    .clk(clk), .rst(rst), .clr_op(clr_op), .load_op(load_op),
    .add_op(add_op), .inv_op(inv_op), .din(din),
    .acc_out(acc_out), .err_out(err_out)
  );

  task automatic check(input string tag, input logic [W-1:0] exp_acc, input logic exp_err);
    n_run++;
    if (acc_out !== exp_acc || err_out !== exp_err) begin
      n_fail++;
      $display("FAIL %s: acc=%h err=%b expected acc=%h err=%b",
               tag, acc_out, err_out, exp_acc, exp_err);
    end
  endtask

  // Inputs are driven after a falling edge. The next rising edge acts on them,
  // and the outputs are sampled at the falling edge that follows.
  task automatic step(input logic c, input logic l, input logic a,
                      input logic i, input logic [W-1:0] d);
    clr_op = c; load_op = l; add_op = a; inv_op = i; din = d;
    @(negedge clk);
    clr_op = 0; load_op = 0; add_op = 0; inv_op = 0;
  endtask

  task automatic t_reset();
    step(0, 1, 0, 0, 16'hAAAA);
    rst = 1'b1;
    step(0, 0, 0, 0, 16'h0000);
    rst = 1'b0;
    check("R1 reset", 16'h0000, 1'b0);
  endtask

  task automatic t_load();
    step(0, 1, 0, 0, 16'h1234);
    check("R3 load", 16'h1234, 1'b0);
  endtask

  task automatic t_add();
    step(0, 0, 1, 0, 16'h0F0F);
    check("R4 add", 16'h2143, 1'b0);
    step(0, 1, 0, 0, 16'hFFFE);
    step(0, 0, 1, 0, 16'h0001);
    check("R4 add to all ones", 16'hFFFF, 1'b0);
  endtask

  task automatic t_complement();
    step(0, 1, 0, 0, 16'h1234);
    step(0, 0, 0, 1, 16'h0000);
    check("R6 complement", 16'hEDCB, 1'b0);
  endtask

  task automatic t_hold();
    step(0, 0, 0, 0, 16'h9999);
    check("R9 idle hold", 16'hEDCB, 1'b0);
  endtask

  task automatic t_overflow_and_lock();
    step(0, 1, 0, 0, 16'hFFFF);
    step(0, 0, 1, 0, 16'h0001);
    check("R5 overflow", 16'hFFFF, 1'b1);
    step(0, 1, 0, 0, 16'h5555);
    check("R7 load blocked", 16'hFFFF, 1'b1);
    step(0, 0, 1, 0, 16'h0000);
    check("R7 add blocked", 16'hFFFF, 1'b1);
    step(0, 0, 0, 1, 16'h0000);
    check("R7 complement blocked", 16'hFFFF, 1'b1);
    step(0, 0, 0, 0, 16'h1111);
    check("R9 idle under error", 16'hFFFF, 1'b1);
  endtask

  task automatic t_clear();
    step(1, 1, 1, 1, 16'h7777);
    check("R2 clear with all strobes while error", 16'h0000, 1'b0);
    step(0, 1, 0, 0, 16'h0042);
    check("R2 operations resume after clear", 16'h0042, 1'b0);
  endtask

  task automatic t_priority();
    step(0, 1, 0, 0, 16'h0010);
    step(0, 1, 1, 0, 16'h0003);
    check("R8 load over add", 16'h0003, 1'b0);
    step(0, 0, 1, 1, 16'h0001);
    check("R8 add over complement", 16'h0004, 1'b0);
    step(0, 1, 0, 1, 16'h00F0);
    check("R8 load over complement", 16'h00F0, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: acc=%h err=%b expected completion", acc_out, err_out);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 state after reset", 16'h0000, 1'b0);
    t_load();
    t_add();
    t_complement();
    t_hold();
    t_overflow_and_lock();
    t_clear();
    t_priority();
    t_reset();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule